// File: doc/BRIEF.md
# Configuration Address/Data Access Bridge

This block sits on the host side of a configuration fabric and lets a processor reach per-function configuration registers through two small I/O windows. The first window is a 32-bit address latch. Software loads it with an enable flag, a bus number, a slot/function pair and a register offset. The second window is the data window. The low two bits of its byte offset are ORed into the latched address, and the result becomes a configuration read or write of 1, 2 or 4 bytes toward the selected downstream function.

The bridge completes some accesses on its own and never forwards them: accesses made while access is disabled, accesses beyond the configuration limit, accesses to absent functions and accesses to functions that are orphaned. Reads of these return all ones and writes are dropped. Every host request gets a response one cycle later. Forwarded reads carry the target's single-cycle read data.

Top module: `cfg_bridge`

## Requirements
- R1: An address-window write (`req_win_i`=0) loads the latch only when `req_off_i`=0 and `req_size_i`=2 (4 bytes). Size codes are 0=1 byte, 1=2 bytes, 2=4 bytes and 3=4 bytes. Any other address-window write leaves the latch unchanged.
- R2: An address-window read returns the whole 32-bit latch value as it stood at the request, whatever the offset and size.
- R3: The latch resets to zero. Latch bit 31 is the access enable. While it is clear, data-window (`req_win_i`=1) writes are not forwarded and data-window reads return 0xFFFFFFFF.
- R4: The effective address is latch[23:0] ORed with `req_off_i`. The bus is bits 23:16, the slot is bits 15:11, the function is bits 10:8 and the register offset is bits 7:0. All of these are presented on the target port.
- R5: A register offset at or above `CFG_LIMIT` is not forwarded. A read to such an offset returns all ones.
- R6: When `tgt_present_i` is low for the decoded function, the access is not forwarded. A read returns all ones and a write is dropped.
- R7: A function flagged hot-added (`tgt_hotplug_i`) whose slot has no function 0 (`tgt_fn0_i` low) is blocked: nothing is forwarded and a read returns all ones. With function 0 present, the access is forwarded.
- R8: The forwarded length is the smaller of the requested size and `CFG_LIMIT` minus the offset. Byte-enable lane i is set for offset[1:0] <= i < offset[1:0]+length, with lanes above 3 cut off.
- R9: A forwarded write raises `tgt_valid_o` and `tgt_write_o` in the request cycle and passes `req_wdata_i` to `tgt_wdata_o` unchanged.
- R10: Every request raises `rsp_valid_o` exactly one cycle later. A forwarded read returns `tgt_rdata_i` of that cycle on the byte lanes it enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Host request strobe, one cycle per request |
| req_win_i | input | 1 | 0 = address window, 1 = data window |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_off_i | input | 2 | Byte offset within the window |
| req_size_i | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| req_wdata_i | input | 32 | Host write data, lane-aligned |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata_o | output | 32 | Response read data |
| tgt_valid_o | output | 1 | Forwarded configuration access |
| tgt_write_o | output | 1 | Forwarded access is a write |
| tgt_bus_o | output | 8 | Decoded bus number |
| tgt_dev_o | output | 5 | Decoded slot |
| tgt_fn_o | output | 3 | Decoded function |
| tgt_off_o | output | 8 | Decoded register offset |
| tgt_be_o | output | 4 | Byte enables of the forwarded access |
| tgt_wdata_o | output | 32 | Write data to the target |
| tgt_present_i | input | 1 | A function answers at the decoded bus/slot/function |
| tgt_hotplug_i | input | 1 | The decoded function was hot-added |
| tgt_fn0_i | input | 1 | Function 0 of the decoded slot is present |
| tgt_rdata_i | input | 32 | Target read data, valid the cycle after a forwarded read |

## Verification
The bench aims at several corner cases:
- Address-window writes of the wrong width or offset. A latch that took them would change the decoded target of every later access.
- Latch low bits combined with the data-window offset. Adding them instead of ORing them, or overwriting them, would move the register offset.
- Offsets that cut an access short at the limit, and offsets that sit beyond the limit. A bridge that forgot to clamp would write bytes past the limit. A bridge that forgot the range check would forward to a register that does not exist.
- Absent and orphaned functions, plus a hot-added function whose slot does have function 0. A wrong blocking rule would either leak accesses to an orphan or refuse a legal one.
- Unaligned 4-byte accesses, whose byte enables must stop at lane 3.

// File: rtl/cfg_bridge_pkg.sv
`timescale 1ns/1ps
package cfg_bridge_pkg;
  localparam int NLANES = 4;
  localparam int DW     = 8 * NLANES;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRSV = 2'd3
  } size_e;

  function automatic logic [2:0] size_bytes(logic [1:0] s);
    case (s)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/cfg_bridge_latch.sv
`timescale 1ns/1ps
module cfg_bridge_latch
  import cfg_bridge_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_win_i,
  input  logic          req_write_i,
  input  logic [1:0]    req_off_i,
  input  logic [1:0]    req_size_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic [DW-1:0] lat_o
);
  logic upd;

  assign upd = req_valid_i && req_write_i && !req_win_i &&
               (req_off_i == 2'd0) && (req_size_i == SZ_WORD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  lat_o <= '0;
    else if (upd) lat_o <= req_wdata_i;
  end

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_write_i && !req_win_i && req_off_i == 2'd0 && req_size_i == 2'd2)
    |=> $stable(lat_o)); // R1
  AST_LATCH_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && !req_win_i && req_off_i == 2'd0 && req_size_i == 2'd2)
    |=> lat_o == $past(req_wdata_i)); // R1
endmodule

// File: rtl/cfg_bridge_decode.sv
`timescale 1ns/1ps
module cfg_bridge_decode
  import cfg_bridge_pkg::*;
#(
  parameter int CFG_LIMIT = 256
) (
  input  logic              en_i,
  input  logic [23:0]       lat_i,
  input  logic [1:0]        off_i,
  input  logic [1:0]        size_i,
  input  logic              present_i,
  input  logic              hotplug_i,
  input  logic              fn0_i,
  output logic [7:0]        bus_o,
  output logic [4:0]        dev_o,
  output logic [2:0]        fn_o,
  output logic [7:0]        reg_o,
  output logic [NLANES-1:0] be_o,
  output logic              ok_o
);
  localparam int LW = 9;
  localparam logic [LW-1:0] LIM = LW'(CFG_LIMIT);

  logic [23:0]   eff;
  logic [LW-1:0] left;
  logic [2:0]    nb, len;
  logic          in_range, orphan;

  assign eff   = lat_i | {22'b0, off_i};
  assign bus_o = eff[23:16];
  assign dev_o = eff[15:11];
  assign fn_o  = eff[10:8];
  assign reg_o = eff[7:0];

  assign in_range = {1'b0, reg_o} < LIM;
  assign left     = LIM - {1'b0, reg_o};
  assign nb       = size_bytes(size_i);
  // left is 1..4 whenever it wins the compare
  assign len      = ({6'b0, nb} < left) ? nb : left[2:0];

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    logic [2:0] lane;
    assign lane    = 3'(i);
    assign be_o[i] = in_range && (lane >= {1'b0, reg_o[1:0]}) &&
                     (lane < ({1'b0, reg_o[1:0]} + len));
  end

  assign orphan = hotplug_i && !fn0_i;
  assign ok_o   = en_i && in_range && present_i && !orphan;
endmodule

// File: rtl/cfg_bridge_resp.sv
`timescale 1ns/1ps
module cfg_bridge_resp
  import cfg_bridge_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_win_i,
  input  logic          req_write_i,
  input  logic          fwd_i,
  input  logic [DW-1:0] lat_i,
  input  logic [DW-1:0] tgt_rdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o
);
  logic          fwd_q;
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      fwd_q       <= 1'b0;
      rdata_q     <= '1;
    end else begin
      rsp_valid_o <= req_valid_i;
      fwd_q       <= req_valid_i && fwd_i && !req_write_i;
      if (req_valid_i) rdata_q <= req_win_i ? '1 : lat_i;
    end
  end

  assign rsp_rdata_o = fwd_q ? tgt_rdata_i : rdata_q;

  AST_RSP_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R10
  AST_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R10
  AST_ADDR_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_win_i && !req_write_i) |=> rsp_rdata_o == $past(lat_i)); // R2
  AST_DROP_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_win_i && !req_write_i && !fwd_i) |=> rsp_rdata_o == '1); // R6
endmodule

// File: rtl/cfg_bridge.sv
`timescale 1ns/1ps
module cfg_bridge
  import cfg_bridge_pkg::*;
#(
  parameter int CFG_LIMIT = 256
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        req_win_i,
  input  logic        req_write_i,
  input  logic [1:0]  req_off_i,
  input  logic [1:0]  req_size_i,
  input  logic [31:0] req_wdata_i,
  output logic        rsp_valid_o,
  output logic [31:0] rsp_rdata_o,
  output logic        tgt_valid_o,
  output logic        tgt_write_o,
  output logic [7:0]  tgt_bus_o,
  output logic [4:0]  tgt_dev_o,
  output logic [2:0]  tgt_fn_o,
  output logic [7:0]  tgt_off_o,
  output logic [3:0]  tgt_be_o,
  output logic [31:0] tgt_wdata_o,
  input  logic        tgt_present_i,
  input  logic        tgt_hotplug_i,
  input  logic        tgt_fn0_i,
  input  logic [31:0] tgt_rdata_i
);
  logic [DW-1:0] lat;
  logic          ok;

  cfg_bridge_latch u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_win_i   (req_win_i),
    .req_write_i (req_write_i),
    .req_off_i   (req_off_i),
    .req_size_i  (req_size_i),
    .req_wdata_i (req_wdata_i),
    .lat_o       (lat)
  );

  cfg_bridge_decode #(.CFG_LIMIT(CFG_LIMIT)) u_decode (
    .en_i      (lat[31]),
    .lat_i     (lat[23:0]),
    .off_i     (req_off_i),
    .size_i    (req_size_i),
    .present_i (tgt_present_i),
    .hotplug_i (tgt_hotplug_i),
    .fn0_i     (tgt_fn0_i),
    .bus_o     (tgt_bus_o),
    .dev_o     (tgt_dev_o),
    .fn_o      (tgt_fn_o),
    .reg_o     (tgt_off_o),
    .be_o      (tgt_be_o),
    .ok_o      (ok)
  );

  assign tgt_valid_o = req_valid_i && req_win_i && ok;
  assign tgt_write_o = req_write_i;
  assign tgt_wdata_o = req_wdata_i;

  cfg_bridge_resp u_resp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_win_i   (req_win_i),
    .req_write_i (req_write_i),
    .fwd_i       (tgt_valid_o),
    .lat_i       (lat),
    .tgt_rdata_i (tgt_rdata_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o)
  );

  AST_FWD_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_valid_o |-> lat[31]); // R3
  AST_FWD_PRESENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_valid_o |-> tgt_present_i); // R6
  AST_NO_ORPHAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_valid_o |-> !(tgt_hotplug_i && !tgt_fn0_i)); // R7
  AST_BE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_valid_o |-> ($countones(tgt_be_o) >= 1 &&
                     $countones(tgt_be_o) <= int'(size_bytes(req_size_i)))); // R8
  AST_FWD_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_valid_o |-> (int'(tgt_off_o) < CFG_LIMIT)); // R5
endmodule

// File: tb/cfg_bridge_bench.sv
`timescale 1ns/1ps
module cfg_bridge_bench;
  localparam int LIM = 192;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_win = 1'b0, req_write = 1'b0;
  logic [1:0]  req_off = '0, req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        tgt_valid, tgt_write;
  logic [7:0]  tgt_bus, tgt_off;
  logic [4:0]  tgt_dev;
  logic [2:0]  tgt_fn;
  logic [3:0]  tgt_be;
  logic [31:0] tgt_wdata;
  logic        tgt_present, tgt_hotplug, tgt_fn0;
  logic [31:0] tgt_rdata = '0;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] shadow = '0;

  typedef struct packed { logic [31:0] d; logic [31:0] m; } item_t;
  item_t exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  cfg_bridge #(.CFG_LIMIT(LIM)) u_cfg_bridge (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_win_i(req_win), .req_write_i(req_write),
    .req_off_i(req_off), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .tgt_valid_o(tgt_valid), .tgt_write_o(tgt_write),
    .tgt_bus_o(tgt_bus), .tgt_dev_o(tgt_dev), .tgt_fn_o(tgt_fn),
    .tgt_off_o(tgt_off), .tgt_be_o(tgt_be), .tgt_wdata_o(tgt_wdata),
    .tgt_present_i(tgt_present), .tgt_hotplug_i(tgt_hotplug), .tgt_fn0_i(tgt_fn0),
    .tgt_rdata_i(tgt_rdata)
  );

  // downstream function population
  function automatic bit is_present(logic [7:0] b, logic [4:0] d, logic [2:0] f);
    if (b == 8'd0 && d < 5'd3) return 1'b1;
    if (b == 8'd0 && d == 5'd3) return f != 3'd0;
    if (b == 8'd1 && d == 5'd2) return f == 3'd0;
    return 1'b0;
  endfunction
  function automatic bit is_hot(logic [7:0] b, logic [4:0] d, logic [2:0] f);
    return (b == 8'd0) && (d == 5'd2 || d == 5'd3) && (f == 3'd1);
  endfunction

  assign tgt_present = is_present(tgt_bus, tgt_dev, tgt_fn);
  assign tgt_hotplug = is_hot(tgt_bus, tgt_dev, tgt_fn);
  assign tgt_fn0     = is_present(tgt_bus, tgt_dev, 3'd0);

  always @(posedge clk)
    if (tgt_valid && !tgt_write)
      tgt_rdata <= {tgt_bus, tgt_dev, tgt_fn, tgt_off, 8'hC3};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic req(input logic win, input logic wr, input logic [1:0] off,
                     input logic [1:0] sz, input logic [31:0] wd, input string tag);
    logic [23:0] eff;
    logic [7:0]  b, ro;
    logic [4:0]  d;
    logic [2:0]  f;
    int nb, len, lo, left;
    logic [3:0]  be;
    logic [31:0] m;
    bit fwd;
    @(negedge clk);
    req_valid = 1'b1; req_win = win; req_write = wr;
    req_off = off; req_size = sz; req_wdata = wd;
    #1;
    if (!win) begin
      chk(tgt_valid == 1'b0, {tag, " addr window not forwarded"}, {31'b0, tgt_valid}, 32'd0);
      if (wr) begin
        exp_q.push_back('{d: 32'd0, m: 32'd0});
        if (off == 2'd0 && sz == 2'd2) shadow = wd;
      end else exp_q.push_back('{d: shadow, m: 32'hFFFF_FFFF});
      tag_q.push_back(tag);
    end else begin
      eff = shadow[23:0] | {22'b0, off};
      b = eff[23:16]; d = eff[15:11]; f = eff[10:8]; ro = eff[7:0];
      fwd = shadow[31] && (int'(ro) < LIM) && is_present(b, d, f) &&
            !(is_hot(b, d, f) && !is_present(b, d, 3'd0));
      nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      left = LIM - int'(ro);
      len = (nb < left) ? nb : left;
      lo = int'(ro[1:0]);
      be = '0;
      for (int i = 0; i < 4; i++) if (i >= lo && i < lo + len) be[i] = 1'b1;
      m = '0;
      for (int i = 0; i < 4; i++) if (be[i]) m[8*i +: 8] = 8'hFF;
      chk(tgt_valid == fwd, {tag, " forward decision"}, {31'b0, tgt_valid}, {31'b0, fwd});
      if (fwd) begin
        chk({tgt_bus, tgt_dev, tgt_fn, tgt_off} == {b, d, f, ro}, {tag, " R4 decode"},
            {8'b0, tgt_bus, tgt_dev, tgt_fn, tgt_off}, {8'b0, b, d, f, ro});
        chk(tgt_be == be, {tag, " R8 byte enables"}, {28'b0, tgt_be}, {28'b0, be});
        chk(tgt_write == wr, {tag, " direction"}, {31'b0, tgt_write}, {31'b0, wr});
        if (wr) chk(tgt_wdata == wd, {tag, " R9 write data"}, tgt_wdata, wd);
      end
      if (wr) exp_q.push_back('{d: 32'd0, m: 32'd0});
      else if (fwd) exp_q.push_back('{d: {b, d, f, ro, 8'hC3}, m: m});
      else exp_q.push_back('{d: 32'hFFFF_FFFF, m: 32'hFFFF_FFFF});
      tag_q.push_back(tag);
    end
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: R10 response one cycle after request
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R10 unexpected response", rsp_valid, 0);
        else begin
          item_t it;
          string t;
          it = exp_q.pop_front();
          t = tag_q.pop_front();
          chk((rsp_rdata & it.m) == (it.d & it.m), {t, " R10 response data"},
              rsp_rdata & it.m, it.d & it.m);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(rsp_valid == 1'b0 && tgt_valid == 1'b0, "R3 reset outputs idle", {31'b0, rsp_valid}, 0);
    @(negedge clk) rst_n = 1'b1;

    // R3: reset latch is zero, access disabled
    req(1'b0, 1'b0, 2'd0, 2'd2, 32'd0, "R3 reset latch");
    req(1'b1, 1'b0, 2'd0, 2'd2, 32'd0, "R3 disabled read");
    req(1'b1, 1'b1, 2'd0, 2'd2, 32'h1234_5678, "R3 disabled write");
    // R1: only offset 0, 4-byte writes load the latch
    req(1'b0, 1'b1, 2'd1, 2'd2, 32'h8000_0100, "R1 wrong offset ignored");
    req(1'b0, 1'b1, 2'd0, 2'd0, 32'h8000_0100, "R1 byte write ignored");
    req(1'b0, 1'b1, 2'd0, 2'd1, 32'h8000_0100, "R1 half write ignored");
    req(1'b0, 1'b0, 2'd0, 2'd2, 32'd0, "R1 latch unchanged");
    req(1'b0, 1'b1, 2'd0, 2'd2, 32'h8000_0210, "R1 full write");
    // R2: read at any offset/size returns whole latch
    req(1'b0, 1'b0, 2'd2, 2'd0, 32'd0, "R2 narrow read");
    req(1'b0, 1'b0, 2'd3, 2'd1, 32'd0, "R2 odd read");
    // R4/R10: forwarded reads
    req(1'b1, 1'b0, 2'd0, 2'd2, 32'd0, "R4 word read");
    req(1'b1, 1'b0, 2'd2, 2'd1, 32'd0, "R8 half read lanes");
    req(1'b1, 1'b0, 2'd3, 2'd2, 32'd0, "R8 word truncated at lane 3");
    req(1'b1, 1'b1, 2'd1, 2'd0, 32'hA1B2_C3D4, "R9 byte write");
    req(1'b1, 1'b1, 2'd0, 2'd2, 32'h0F1E_2D3C, "R9 word write");
    // R4: latch low bits ORed with offset
    req(1'b0, 1'b1, 2'd0, 2'd2, 32'h8000_0212, "R4 latch low bits");
    req(1'b1, 1'b0, 2'd1, 2'd0, 32'd0, "R4 offset OR");
    // R4: another bus
    req(1'b0, 1'b1, 2'd0, 2'd2, 32'h8001_1004, "R4 bus1 slot2");
    req(1'b1, 1'b0, 2'd0, 2'd2, 32'd0, "R4 bus1 read");
    // R6: absent function
    req(1'b0, 1'b1, 2'd0, 2'd2, 32'h8001_1804, "R6 absent slot");
    req(1'b1, 1'b0, 2'd0, 2'd2, 32'd0, "R6 absent read");
    req(1'b1, 1'b1, 2'd0, 2'd2, 32'hDEAD_BEEF, "R6 absent write");
    // R8/R5: limit clamp and range
    req(1'b0, 1'b1, 2'd0, 2'd2, 32'h8000_00BC, "R8 near limit");
    req(1'b1, 1'b0, 2'd2, 2'd2, 32'd0, "R8 clamp to limit");
    req(1'b1, 1'b0, 2'd0, 2'd2, 32'd0, "R8 last word in range");
    req(1'b0, 1'b1, 2'd0, 2'd2, 32'h8000_00C0, "R5 at limit");
    req(1'b1, 1'b0, 2'd0, 2'd2, 32'd0, "R5 read at limit");
    req(1'b1, 1'b1, 2'd0, 2'd2, 32'h5555_5555, "R5 write at limit");
    req(1'b0, 1'b1, 2'd0, 2'd2, 32'h8000_00FC, "R5 past limit");
    req(1'b1, 1'b0, 2'd3, 2'd0, 32'd0, "R5 read past limit");
    // R7: orphan vs hot-added with function 0
    req(1'b0, 1'b1, 2'd0, 2'd2, 32'h8000_1900, "R7 orphan function");
    req(1'b1, 1'b0, 2'd0, 2'd2, 32'd0, "R7 orphan read");
    req(1'b1, 1'b1, 2'd0, 2'd2, 32'h7777_7777, "R7 orphan write");
    req(1'b0, 1'b1, 2'd0, 2'd2, 32'h8000_1100, "R7 hot with fn0");
    req(1'b1, 1'b0, 2'd0, 2'd2, 32'd0, "R7 hot with fn0 read");
    // R3: disable again
    req(1'b0, 1'b1, 2'd0, 2'd2, 32'h0000_0210, "R3 clear enable");
    req(1'b1, 1'b0, 2'd0, 2'd2, 32'd0, "R3 read after disable");
    idle(4);
    chk(exp_q.size() == 0, "R10 all responses seen", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule